// File: doc/BRIEF.md
# Prioritized Interrupt Flag Controller

This block gathers interrupt events from a set of peripheral sources and keeps one sticky pending bit for each source. Each pending bit is gated by an enable for that source and by one global enable. From the requests that remain, a fixed-priority picker chooses one winner. The winner goes to the CPU as a request line and a vector number. When the CPU accepts the request, the global enable drops. The CPU can restore the global enable on a return from interrupt, or software can set it again.

Each source has a clear-mode bit. In automatic mode, the source's bit clears when its vector is acknowledged. In software mode, the bit stays set until software writes a clear. A contiguous range of sources can share one vector while every member keeps its own flag. A group status register tells the handler which member to serve next.

Software reaches the flags, enables, clear modes, global enable and group status through a small synchronous register port. Writes take effect on the clock edge. Reads are combinational from the address.

Top module: `irq_flag_ctrl`

## Requirements
- R1: A one-cycle pulse on `evt[i]` sets pending bit i on the next edge, whatever the state of enable bit i. Pending bits read back at register address 0.
- R2: Each source holds one pending bit. Further events on a source that is already pending are dropped, so a single clear returns the bit to 0.
- R3: `irq_req` is high exactly when some source has its pending bit, its enable bit and the global enable all set. Writing an enable for a bit that is already pending raises `irq_req` with no further edge.
- R4: Source 0 has the highest priority and priority falls with the index. The vector is the binary index of the winning source.
- R5: An acknowledge while `irq_req` is high clears the global enable, so `irq_req` is low in the following cycle. No request is presented again until the global enable is set by a write or by a return.
- R6: A pulse on `reti` loads the global enable from `reti_gie`.
- R7: On an accepted acknowledge, the winner's pending bit clears if its mode bit is 1 (automatic). It stays set if its mode bit is 0 (software).
- R8: A write to address 0 clears each pending bit whose data bit is 1 and leaves the other bits unchanged.
- R9: When an event and a clear reach the same pending bit in the same cycle, the bit stays set.
- R10: Sources GRP_LO..GRP_HI (default 4..6) all present vector GRP_LO. After one member is cleared, any other member that is still eligible keeps requesting that vector.
- R11: Address 4 reads the index of the lowest-numbered pending group member, or all ones when no member is pending.
- R12: Address 1 holds the enables, address 2 the mode bits and bit 0 of address 3 the global enable, all readable and writable. An acknowledge while `irq_req` is low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt | input | NSRC | Per-source event pulses |
| irq_req | output | 1 | Request to CPU |
| irq_vec | output | IW | Vector number of the winning request |
| irq_ack | input | 1 | CPU accepts the current request |
| reti | input | 1 | Return from interrupt |
| reti_gie | input | 1 | Global enable restored on return |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | NSRC | Register write data |
| reg_rdata | output | NSRC | Register read data |

## Verification
The assertions assume that `irq_ack` is only meaningful while `irq_req` is high, that `reti` and an acknowledge do not arrive in the same cycle, and that `evt` is held low during reset. The stimulus drives every input on the falling edge and asserts acknowledge only after it has seen the request. It separates return pulses from acknowledges by at least one cycle. The flag sweep keeps the global enable off while events are pulsed, so each winner is observed only once all flags have landed.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
    typedef enum logic [2:0] {
        RA_FLAG = 3'd0,
        RA_EN   = 3'd1,
        RA_MODE = 3'd2,
        RA_GIE  = 3'd3,
        RA_GRP  = 3'd4
    } reg_addr_e;

    function automatic logic in_grp(input int unsigned s, input int unsigned lo,
                                    input int unsigned hi);
        return (s >= lo) && (s <= hi);
    endfunction
endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic          vld,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
        vld = |req;
    end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)            pend_o[g] <= 1'b0;
            else if (set_i[g])  pend_o[g] <= 1'b1;
            else if (clr_i[g])  pend_o[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irq_flag_pkg::*;
#(
    parameter int NSRC   = 8,
    parameter int GRP_LO = 4,
    parameter int GRP_HI = 6,
    localparam int IW    = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] evt,
    output logic            irq_req,
    output logic [IW-1:0]   irq_vec,
    input  logic            irq_ack,
    input  logic            reti,
    input  logic            reti_gie,
    input  logic            reg_we,
    input  logic [2:0]      reg_addr,
    input  logic [NSRC-1:0] reg_wdata,
    output logic [NSRC-1:0] reg_rdata
);
    logic [NSRC-1:0] pend, en, mode, elig, grp_mask, grp_pend;
    logic [NSRC-1:0] sw_clr, ack_clr;
    logic            gie, win_vld, grp_vld, take;
    logic [IW-1:0]   win_idx, grp_idx;
    reg_addr_e       ra;

    assign ra = reg_addr_e'(reg_addr);

    for (genvar g = 0; g < NSRC; g++) begin : g_grp
        assign grp_mask[g] = in_grp(g, GRP_LO, GRP_HI);
    end

    assign elig     = pend & en & {NSRC{gie}};
    assign grp_pend = pend & grp_mask;

    irq_pick #(.N(NSRC), .IW(IW)) u_win (.req(elig),     .vld(win_vld), .idx(win_idx));
    irq_pick #(.N(NSRC), .IW(IW)) u_grp (.req(grp_pend), .vld(grp_vld), .idx(grp_idx));

    assign irq_req = win_vld;
    assign irq_vec = grp_mask[win_idx] ? IW'(GRP_LO) : win_idx;
    assign take    = irq_ack && win_vld;

    always_comb begin
        sw_clr  = (reg_we && ra == RA_FLAG) ? reg_wdata : '0;
        ack_clr = (take && mode[win_idx]) ? (NSRC'(1) << win_idx) : '0;
    end

    irq_flag_bank #(.N(NSRC)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .set_i (evt),
        .clr_i (sw_clr | ack_clr),
        .pend_o(pend)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en   <= '0;
            mode <= '0;
            gie  <= 1'b0;
        end else begin
            if (reg_we && ra == RA_EN)   en   <= reg_wdata;
            if (reg_we && ra == RA_MODE) mode <= reg_wdata;
            if (take)                        gie <= 1'b0;
            else if (reti)                   gie <= reti_gie;
            else if (reg_we && ra == RA_GIE) gie <= reg_wdata[0];
        end
    end

    always_comb begin
        case (ra)
            RA_FLAG: reg_rdata = pend;
            RA_EN:   reg_rdata = en;
            RA_MODE: reg_rdata = mode;
            RA_GIE:  reg_rdata = NSRC'(gie);
            RA_GRP:  reg_rdata = grp_vld ? NSRC'(grp_idx) : '1;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk #(
    parameter int NSRC = 8,
    parameter int IW   = 3
) (
    input logic            clk,
    input logic            rst,
    input logic [NSRC-1:0] evt,
    input logic [NSRC-1:0] pend,
    input logic [NSRC-1:0] en,
    input logic            gie,
    input logic            irq_req,
    input logic [IW-1:0]   irq_vec,
    input logic            irq_ack,
    input logic            reg_we,
    input logic [2:0]      reg_addr
);
    for (genvar g = 0; g < NSRC; g++) begin : g_flag
        // R1
        evt_latch_chk: assert property (@(posedge clk) disable iff (rst)
            evt[g] |=> pend[g]);
        // R7
        no_spurious_clear_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(pend[g]) |-> $past(irq_ack || (reg_we && reg_addr == 3'd0)));
    end

    // R3
    req_gated_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (gie && |(pend & en)));

    // R4
    prio_order_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (((pend & en) & ((NSRC'(1) << irq_vec) - NSRC'(1))) == '0));

    // R5
    ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && irq_req) |=> (!irq_req && !gie));
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(.NSRC(NSRC), .IW(IW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .evt     (evt),
    .pend    (pend),
    .en      (en),
    .gie     (gie),
    .irq_req (irq_req),
    .irq_vec (irq_vec),
    .irq_ack (irq_ack),
    .reg_we  (reg_we),
    .reg_addr(reg_addr)
);

// File: tb/sim_irq_flag_ctrl.sv
module sim_irq_flag_ctrl;
    localparam int NSRC = 8;
    localparam int IW   = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] evt = '0;
    logic            irq_req;
    logic [IW-1:0]   irq_vec;
    logic            irq_ack = 1'b0, reti = 1'b0, reti_gie = 1'b0, reg_we = 1'b0;
    logic [2:0]      reg_addr = 3'd0;
    logic [NSRC-1:0] reg_wdata = '0;
    logic [NSRC-1:0] reg_rdata;

    int tests = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_flag_ctrl #(.NSRC(NSRC), .GRP_LO(4), .GRP_HI(6)) u0 (
        .clk(clk), .rst(rst), .evt(evt), .irq_req(irq_req), .irq_vec(irq_vec),
        .irq_ack(irq_ack), .reti(reti), .reti_gie(reti_gie), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [NSRC-1:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        reg_addr = a;
        #1 v = int'(reg_rdata);
    endtask

    task automatic pulse(input logic [NSRC-1:0] m);
        evt = m;
        tick();
        evt = '0;
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        tick();
        irq_ack = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int v, lo, glo, expv;
        @(negedge clk); tick(); tick();
        rst = 1'b0;
        @(negedge clk);

        // Reset state
        check("reset req", int'(irq_req), 0);
        rd(0, v); check("reset flags", v, 0);
        rd(3, v); check("reset gie", v, 0);
        rd(4, v); check("R11 reset grp none", v, 255);

        // Near-exhaustive sweep over flag patterns (R1, R4, R10, R11)
        for (int m = 1; m < 256; m++) begin
            wr(0, 8'hFF); wr(3, 8'h00); wr(1, 8'hFF);
            pulse(NSRC'(m));
            wr(3, 8'h01);
            lo = 8; glo = 255;
            for (int b = 7; b >= 0; b--) begin
                if (m[b]) lo = b;
                if (m[b] && b >= 4 && b <= 6) glo = b;
            end
            expv = (lo >= 4 && lo <= 6) ? 4 : lo;
            rd(0, v); check("R1 sweep flags", v, m);
            check("R3 sweep req", int'(irq_req), 1);
            check("R4 sweep vec", int'(irq_vec), expv);
            rd(4, v); check("R11 sweep grp", v, glo);
        end

        // R12 register readback
        wr(0, 8'hFF); wr(1, 8'h00); wr(2, 8'hA5); wr(3, 8'h01);
        rd(2, v); check("R12 mode readback", v, 8'hA5);
        wr(2, 8'h00);
        rd(1, v); check("R12 enable readback", v, 0);

        // R1 latch while masked
        pulse(8'h08);
        rd(0, v); check("R1 masked latch", v, 8'h08);
        check("R3 masked no req", int'(irq_req), 0);
        // R2 repeat lost: one clear suffices
        pulse(8'h08);
        rd(0, v); check("R2 still single", v, 8'h08);
        wr(0, 8'h08);
        rd(0, v); check("R2 single clear", v, 0);

        // R3 enabling pending source
        pulse(8'h04);
        check("R3 no req before en", int'(irq_req), 0);
        wr(1, 8'h04);
        check("R3 req on enable", int'(irq_req), 1);
        check("R3 vec", int'(irq_vec), 2);

        // R5 ack, R7 software mode keeps flag, R8 partial clear
        pulse(8'h01); wr(1, 8'h05);
        check("R4 higher wins", int'(irq_vec), 0);
        ack();
        check("R5 req low after ack", int'(irq_req), 0);
        rd(3, v); check("R5 gie cleared", v, 0);
        rd(0, v); check("R7 sw mode keeps", v, 8'h05);
        pulse(8'h02); wr(1, 8'h07);
        tick(); tick();
        check("R5 higher still held", int'(irq_req), 0);
        wr(0, 8'h02);
        rd(0, v); check("R8 partial clear", v, 8'h05);

        // R6 return reloads gie
        reti = 1'b1; reti_gie = 1'b1; tick(); reti = 1'b0;
        check("R6 reti req", int'(irq_req), 1);
        check("R6 reti vec", int'(irq_vec), 0);
        reti = 1'b1; reti_gie = 1'b0; tick(); reti = 1'b0;
        rd(3, v); check("R6 reti zero", v, 0);

        // R7 automatic clear
        wr(0, 8'hFF); wr(2, 8'h02); wr(1, 8'h02); wr(3, 8'h01);
        pulse(8'h02);
        check("R7 auto req", int'(irq_req), 1);
        ack();
        rd(0, v); check("R7 auto cleared", v, 0);
        wr(2, 8'h00);

        // R9 set wins over clear
        evt = 8'h20; reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h20;
        tick();
        evt = '0; reg_we = 1'b0;
        rd(0, v); check("R9 set wins", v, 8'h20);
        wr(0, 8'hFF);

        // R10 grouped vector
        wr(1, 8'h70); wr(3, 8'h01);
        pulse(8'h50);
        check("R10 grp vec", int'(irq_vec), 4);
        rd(4, v); check("R11 grp first", v, 4);
        wr(0, 8'h10);
        check("R10 grp re-req", int'(irq_req), 1);
        check("R10 grp same vec", int'(irq_vec), 4);
        rd(4, v); check("R11 grp next", v, 6);
        wr(0, 8'h40);
        check("R10 grp done", int'(irq_req), 0);
        rd(4, v); check("R11 grp none", v, 255);

        // R12 ack while no request is ignored
        ack();
        rd(3, v); check("R12 idle ack gie", v, 1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule